// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block divides the core clock down to the oversampling tick used by a serial
transmitter and receiver. A 16-bit whole divisor sets the base period in clocks. A
3-bit fraction lengthens the average period in steps of one eighth of a clock: some
tick periods are stretched by one clock and the rest are not, so the mean period over
a group of eight ticks is the divisor plus the fraction divided by eight. The tick is a
registered pulse one clock wide.

Software programs the divisor through a single write port that selects between two
targets: the divisor word and a protection word. A protection write takes effect only
if it carries the correct 24-bit key. Its low bit then locks or unlocks the divisor.
While the divisor is locked, divisor writes are dropped. A written divisor waits in a
shadow register and is adopted only when the current period ends, so no tick period
is ever cut short. A whole divisor of zero halts the tick.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `tick` is low, protection is off and the divisor is zero, so no tick appears until a divisor is written.
- R2: A write with `cfg_sel` = 0 targets the divisor word: bits 15:0 of `cfg_wdata` are the whole divisor and bits 18:16 are the fraction in eighths.
- R3: With a fraction of zero and a whole divisor D of 2 or more, `tick` is high for exactly one clock, once every D clocks.
- R4: With a fraction F, any 8 consecutive tick periods contain exactly F periods of D+1 clocks, and the rest last D clocks. Their total is 8*D+F clocks.
- R5: Writing a whole divisor of zero stops the tick once the period in progress has ended. No tick follows while the divisor stays zero.
- R6: A new divisor is adopted at the end of the period in progress, and that period keeps its old length. When the tick is halted, a new divisor is adopted on the next clock, and the first tick rises D+1 clocks after the write has landed.
- R7: A write with `cfg_sel` = 1 targets protection. Only if bits 31:8 equal 0x555341 does bit 0 set the lock (1) or clear it (0). A write with any other key leaves the lock unchanged.
- R8: While the lock is set, divisor writes have no effect on the tick.
- R9: A 3-bit accumulator, cleared while the tick is halted, adds the fraction at every period boundary. The period that starts there is stretched by one clock exactly when that addition overflows past 7.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe, one clock per write |
| cfg_sel | input | 1 | Write target: 0 divisor word, 1 protection word |
| cfg_wdata | input | 32 | Write data |
| tick | output | 1 | Oversampling tick, one clock wide |

## Verification
A write driven before a rising edge lands in the shadow or lock register on that edge. The new divisor appears in the tick spacing only from the next period boundary onward. The tick itself rises on the boundary edge, because it is registered on that same edge. The bench drives and samples on falling edges and updates a behavioural model on rising edges, so the model and `tick` are compared once per clock. The spacing checks take gaps between tick observations only after one tick of resynchronisation that follows each write. When the tick restarts from a halt, the delay of the first tick is counted from the edge on which the write lands.

// File: rtl/baud_tick_pkg.sv
// Shared types for the baud tick generator.
package baud_tick_pkg;
    typedef enum logic {
        CFG_DIVISOR = 1'b0,
        CFG_PROTECT = 1'b1
    } cfg_target_e;
endpackage

// File: rtl/baud_cfg_guard.sv
// Configuration guard: keeps the protection lock and the shadow divisor.
// Assumes one-cycle write strobes; protection writes need the key in the top bits.
module baud_cfg_guard
    import baud_tick_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CD_W   = 16,
    parameter int FP_W   = 3,
    parameter int KEY_W  = 24,
    parameter logic [KEY_W-1:0] KEY = 24'h555341
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  cfg_target_e       cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              locked,
    output logic [CD_W-1:0]   pend_cd,
    output logic [FP_W-1:0]   pend_fp
);
    localparam int KEY_LSB = DATA_W - KEY_W;
    localparam int FP_LSB  = CD_W;

    logic key_ok;
    assign key_ok = (cfg_wdata[DATA_W-1:KEY_LSB] == KEY);

    // Lock flag: changes only on a keyed protection write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
        end else if (cfg_wr && cfg_sel == CFG_PROTECT && key_ok) begin
            locked <= cfg_wdata[0];
        end
    end

    // Shadow divisor: accepts divisor writes while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_cd <= '0;
            pend_fp <= '0;
        end else if (cfg_wr && cfg_sel == CFG_DIVISOR && !locked) begin
            pend_cd <= cfg_wdata[CD_W-1:0];
            pend_fp <= cfg_wdata[FP_LSB +: FP_W];
        end
    end
endmodule

// File: rtl/baud_frac_dither.sv
// Fractional dither: an accumulator adds the fraction at each boundary and
// flags a one-clock stretch of the next period on overflow.
// Assumes `advance` is high exactly on period boundaries.
module baud_frac_dither #(
    parameter int FP_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance,
    input  logic            restart,
    input  logic [FP_W-1:0] frac,
    output logic            stretch
);
    logic [FP_W-1:0] acc;
    logic [FP_W:0]   sum;

    // Sum from a cleared base while halted, else from the running accumulator.
    always_comb begin
        sum = {1'b0, (restart ? {FP_W{1'b0}} : acc)} + {1'b0, frac};
    end

    assign stretch = sum[FP_W];

    // Accumulator update at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (advance) begin
            acc <= sum[FP_W-1:0];
        end
    end
endmodule

// File: rtl/baud_div_counter.sv
// Period counter: counts each period down, adopts the shadow divisor at each
// boundary and registers the tick. A zero active divisor is a halted state in
// which every clock counts as a boundary.
module baud_div_counter #(
    parameter int CD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CD_W-1:0] next_cd,
    input  logic            stretch,
    output logic [CD_W-1:0] act_cd,
    output logic            idle,
    output logic            boundary,
    output logic            tick
);
    logic [CD_W-1:0] cnt;
    logic [CD_W-1:0] span;

    assign idle     = (act_cd == '0);
    assign boundary = idle || (cnt == '0);
    assign span     = next_cd + CD_W'(stretch) - CD_W'(1);

    // Countdown, divisor adoption and registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cd <= '0;
            cnt    <= '0;
            tick   <= 1'b0;
        end else if (boundary) begin
            act_cd <= next_cd;
            cnt    <= (next_cd == '0) ? '0 : span;
            tick   <= !idle;
        end else begin
            cnt    <= cnt - CD_W'(1);
            tick   <= 1'b0;
        end
    end
endmodule

// File: rtl/baud_tick_gen.sv
// Fractional baud tick generator top: guarded configuration, fractional dither
// and period counter. Assumes a synchronous active-low reset.
module baud_tick_gen
    import baud_tick_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CD_W   = 16,
    parameter int FP_W   = 3,
    parameter int KEY_W  = 24,
    parameter logic [KEY_W-1:0] KEY = 24'h555341
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              tick
);
    cfg_target_e     sel_e;
    logic            locked;
    logic [CD_W-1:0] pend_cd;
    logic [FP_W-1:0] pend_fp;
    logic [CD_W-1:0] act_cd;
    logic            idle;
    logic            boundary;
    logic            stretch;

    assign sel_e = cfg_target_e'(cfg_sel);

    baud_cfg_guard #(
        .DATA_W(DATA_W), .CD_W(CD_W), .FP_W(FP_W), .KEY_W(KEY_W), .KEY(KEY)
    ) guard_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(sel_e),
        .cfg_wdata(cfg_wdata), .locked(locked), .pend_cd(pend_cd), .pend_fp(pend_fp)
    );

    baud_frac_dither #(.FP_W(FP_W)) dither_i (
        .clk(clk), .rst_n(rst_n), .advance(boundary), .restart(idle),
        .frac(pend_fp), .stretch(stretch)
    );

    baud_div_counter #(.CD_W(CD_W)) counter_i (
        .clk(clk), .rst_n(rst_n), .next_cd(pend_cd), .stretch(stretch),
        .act_cd(act_cd), .idle(idle), .boundary(boundary), .tick(tick)
    );
endmodule

// File: rtl/baud_tick_chk.sv
// Assertion checker for baud_tick_gen, attached by bind.
module baud_tick_chk
    import baud_tick_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CD_W   = 16,
    parameter int FP_W   = 3,
    parameter int KEY_W  = 24,
    parameter logic [KEY_W-1:0] KEY = 24'h555341
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              cfg_sel,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic              tick,
    input logic              locked,
    input logic [CD_W-1:0]   pend_cd,
    input logic [FP_W-1:0]   pend_fp,
    input logic [CD_W-1:0]   act_cd,
    input logic              boundary
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!tick && !locked));

    // R5
    stop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cd == '0) |=> !tick);

    // R3
    tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && act_cd > CD_W'(1)) |=> !tick);

    // R8
    lock_holds_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && cfg_wr && cfg_sel == CFG_DIVISOR) |=> ($stable(pend_cd) && $stable(pend_fp)));

    // R7
    bad_key_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == CFG_PROTECT && cfg_wdata[DATA_W-1 -: KEY_W] != KEY) |=> $stable(locked));

    // R6
    midperiod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(act_cd));
endmodule

bind baud_tick_gen baud_tick_chk #(
    .DATA_W(DATA_W), .CD_W(CD_W), .FP_W(FP_W), .KEY_W(KEY_W), .KEY(KEY)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tick(tick), .locked(locked), .pend_cd(pend_cd),
    .pend_fp(pend_fp), .act_cd(act_cd), .boundary(boundary)
);

// File: tb/baud_tick_gen_tb_top.sv
// Bench: behavioural reference model compared every clock, plus spacing checks.
module baud_tick_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Reference model state
    bit m_lock;
    int m_pcd, m_pfp, m_acd, m_cnt, m_acc;
    bit m_tick = 1'b0;

    always #2 clk = ~clk;

    baud_tick_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .tick(tick)
    );

    // Reference model: advances on each rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_lock = 0; m_pcd = 0; m_pfp = 0; m_acd = 0; m_cnt = 0; m_acc = 0; m_tick = 0;
        end else begin
            bit halted;
            halted = (m_acd == 0);
            if (halted || m_cnt == 0) begin
                int s;
                s = (halted ? 0 : m_acc) + m_pfp;
                m_acc  = s % 8;
                m_tick = !halted;
                m_acd  = m_pcd;
                m_cnt  = (m_pcd == 0) ? 0 : m_pcd + (s >= 8 ? 1 : 0) - 1;
            end else begin
                m_cnt  = m_cnt - 1;
                m_tick = 0;
            end
            if (cfg_wr) begin
                if (cfg_sel) begin
                    if (cfg_wdata[31:8] == 24'h555341) m_lock = cfg_wdata[0];
                end else if (!m_lock) begin
                    m_pcd = int'(cfg_wdata[15:0]);
                    m_pfp = int'(cfg_wdata[18:16]);
                end
            end
        end
    end

    // Per-clock comparison against the model (R9).
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (tick !== m_tick) begin
                errors++;
                $display("FAIL R9 cycle %0d: tick=%b expected %b", cyc, tick, m_tick);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    function automatic logic [31:0] div_word(input int cd, input int fp);
        return {13'b0, 3'(fp), 16'(cd)};
    endfunction

    task automatic next_tick(output int t);
        @(negedge clk);
        while (tick !== 1'b1) @(negedge clk);
        t = cyc;
    endtask

    task automatic window(input int cd, input int fp, input string req);
        int t0, t1, sum;
        sum = 0;
        next_tick(t0);
        for (int i = 0; i < 8; i++) begin
            next_tick(t1);
            if (t1 - t0 != cd && t1 - t0 != cd + 1) chk(1'b0, req, t1 - t0, cd);
            sum += t1 - t0;
            t0 = t1;
        end
        chk(sum == 8 * cd + fp, req, sum, 8 * cd + fp);
    endtask

    initial begin
        int t0, t1, t2, n, c1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet after reset
        n = 0;
        repeat (30) begin @(negedge clk); if (tick) n++; end
        chk(n == 0, "R1 no tick after reset", n, 0);

        // R2 / R3: whole divisor 4, no fraction
        wr(1'b0, div_word(4, 0));
        next_tick(t0);
        next_tick(t0);
        @(negedge clk);
        chk(tick == 1'b0, "R3 tick one clock wide", int'(tick), 0);
        for (int i = 0; i < 4; i++) begin
            next_tick(t1);
            chk(t1 - t0 == 4, "R2 R3 period", t1 - t0, 4);
            t0 = t1;
        end

        // R4: fractional spacing
        wr(1'b0, div_word(5, 3));
        next_tick(t0);
        window(5, 3, "R4 cd5 fp3");
        window(5, 3, "R4 cd5 fp3 second");
        wr(1'b0, div_word(2, 7));
        next_tick(t0);
        window(2, 7, "R4 cd2 fp7");

        // R6: change in mid-period
        wr(1'b0, div_word(20, 0));
        next_tick(t0);
        next_tick(t0);
        repeat (3) @(negedge clk);
        wr(1'b0, div_word(3, 0));
        next_tick(t1);
        chk(t1 - t0 == 20, "R6 old period completes", t1 - t0, 20);
        next_tick(t2);
        chk(t2 - t1 == 3, "R6 new period adopted", t2 - t1, 3);

        // R8: locked divisor
        wr(1'b1, {24'h555341, 8'h01});
        wr(1'b0, div_word(7, 0));
        next_tick(t0);
        next_tick(t0);
        next_tick(t1);
        chk(t1 - t0 == 3, "R8 locked write ignored", t1 - t0, 3);

        // R7: wrong key does not unlock
        wr(1'b1, {24'h555340, 8'h00});
        wr(1'b0, div_word(7, 0));
        next_tick(t0);
        next_tick(t0);
        next_tick(t1);
        chk(t1 - t0 == 3, "R7 wrong key ignored", t1 - t0, 3);

        // R7: correct key unlocks
        wr(1'b1, {24'h555341, 8'h00});
        wr(1'b0, div_word(7, 0));
        next_tick(t0);
        next_tick(t1);
        chk(t1 - t0 == 7, "R7 unlock by key", t1 - t0, 7);

        // R5: zero divisor halts
        wr(1'b0, div_word(0, 5));
        next_tick(t0);
        n = 0;
        repeat (100) begin @(negedge clk); if (tick) n++; end
        chk(n == 0, "R5 halted", n, 0);

        // R6: restart from halt
        wr(1'b0, div_word(6, 0));
        c1 = cyc;
        next_tick(t1);
        chk(t1 - c1 == 7, "R6 first tick after restart", t1 - c1, 7);
        next_tick(t2);
        chk(t2 - t1 == 6, "R6 restart period", t2 - t1, 6);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL R9 watchdog: cycle %0d expected completion before %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule